// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Path

This block sits between a 16-bit peripheral that issues DMA requests and a byte-addressed memory port. Each request carries a start address, a byte length, a direction (peripheral-to-memory or memory-to-peripheral) and a flag that bypasses swapping. The block forms the memory address by OR-ing the request address with a programmable high-address register. It then moves the data one 16-bit halfword per memory beat.

In swap mode the block clears bit 0 of both the address and the length before it starts. It then exchanges the two bytes of every halfword in both directions. Writes to memory in this mode are split into bursts of at most 64 bytes. In bypass mode the data moves unchanged at the given address and length. A request that ends with an odd byte count is finished with a single-byte beat. The memory port stalls beats through a grant input. The block accepts a new request only when it is idle, and it signals completion with a one-cycle pulse.

Byte lane convention: data bits [7:0] carry the byte at `mem_addr` and bits [15:8] carry the byte at `mem_addr+1`. `mem_be[0]` enables the low lane and `mem_be[1]` enables the high lane.

Top module: `hswap_dma_path`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req`, `done`, `per_wtake` and `per_rvalid` are 0. The high-address register holds 0.
- R2: The first beat's `mem_addr` is `req_addr` OR the high-address register value at acceptance, with bit 0 cleared in swap mode. Writes to the register during a transfer do not change that transfer's addresses.
- R3: With `req_raw`=1, the transfer makes ceil(len/2) beats at unchanged address and length, and the data passes unswapped. Every beat has `mem_be`=2'b11, except that the last beat of an odd length has `mem_be`=2'b01.
- R4: With `req_raw`=0, bit 0 of the address and of the length is cleared. The transfer makes len/2 beats, every one with `mem_be`=2'b11 and an even `mem_addr`.
- R5: In swap mode, `mem_wdata` = {`per_wdata`[7:0], `per_wdata`[15:8]} on writes, and `per_rdata` = {`mem_rdata`[7:0], `mem_rdata`[15:8]} on reads.
- R6: Successive beats advance `mem_addr` by 2. `mem_first` marks the first beat of each burst. Swapped writes start a new burst every 32 beats (64 bytes). Every other mode is a single burst, with `mem_first` set only on beat 0.
- R7: A request whose aligned length is 0 issues no `mem_req`. It raises `done` in the cycle after acceptance.
- R8: `req_ready` is 0 from acceptance until the cycle after `done`. A `req_valid` during that time starts nothing.
- R9: `done` is high for exactly one cycle, the cycle after the clock edge at which the last beat is granted.
- R10: While `mem_req`=1 and `mem_gnt`=0, `mem_addr`, `mem_be` and `mem_first` hold, `per_wtake` stays 0, and no beat is skipped.
- R11: For each granted read beat, `per_rvalid` is 1 for one cycle in the following cycle, with that beat's data. `per_rvalid` is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_we | input | 1 | Load the high-address register |
| hi_wdata | input | AW | New high-address value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Length in bytes |
| req_wr | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| req_raw | input | 1 | 1: bypass swapping and alignment |
| per_wdata | input | 16 | Peripheral halfword for the current write beat |
| per_wtake | output | 1 | Write beat consumed `per_wdata` this cycle |
| per_rdata | output | 16 | Halfword returned to the peripheral |
| per_rvalid | output | 1 | `per_rdata` valid |
| mem_req | output | 1 | Beat request to memory |
| mem_gnt | input | 1 | Memory accepts the beat this cycle |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Beat byte address |
| mem_be | output | 2 | Byte-lane enables |
| mem_first | output | 1 | First beat of a burst |
| mem_wdata | output | 16 | Write data to memory |
| mem_rdata | input | 16 | Read data, valid in the granted cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong remaining-length count shows up at once as a wrong beat count, a wrong last-beat `mem_be`, or a `done` that comes early or late. The bench counts beats and pins `done` to the exact cycle after the final grant. A corrupted address or burst index shows up on the very next granted beat as a `mem_addr` off the +2 sequence or a misplaced `mem_first`. Long swapped writes with stalls check this across burst boundaries 32 and 64. A stale swap or direction flag shows up within one beat as byte-reversed data, on `mem_wdata` or on `per_rdata` one cycle later.

// File: rtl/hswap_pkg.sv
package hswap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_FIN  = 2'd2
    } seq_st_e;
endpackage

// File: rtl/hswap_lane.sv
// Byte-order unit: reverses byte order of a LANES-byte word when swap_en is set.
module hswap_lane #(
    parameter int LANES = 2,
    localparam int DW = LANES * 8
) (
    input  logic [DW-1:0] din,
    input  logic          swap_en,
    output logic [DW-1:0] dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_byte
        assign dout[g*8 +: 8] = swap_en ? din[(LANES-1-g)*8 +: 8] : din[g*8 +: 8];
    end
endmodule

// File: rtl/hswap_seq.sv
// Beat sequencer: alignment, remaining-length count, burst index, done pulse.
module hswap_seq
    import hswap_pkg::*;
#(
    parameter int AW          = 32,
    parameter int LW          = 16,
    parameter int BURST_BYTES = 64,
    localparam int BEATS      = BURST_BYTES / 2,
    localparam int BIDX_W     = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          req_wr,
    input  logic          req_raw,
    input  logic [AW-1:0] hi_val,
    input  logic          mem_gnt,
    output logic          req_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_be,
    output logic          mem_first,
    output logic          swap_on,
    output logic          done
);
    typedef struct packed {
        seq_st_e           st;
        logic [AW-1:0]     addr;
        logic [LW-1:0]     rem;
        logic              we;
        logic              swap;
        logic              first;
        logic [BIDX_W-1:0] bidx;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic [AW-1:0] base_d;
    logic [LW-1:0] len_d;
    logic          split_d;

    always_comb begin
        nxt_d   = cur_q;
        base_d  = req_addr | hi_val;
        len_d   = req_len;
        split_d = cur_q.we && cur_q.swap;
        if (!req_raw) begin
            base_d[0] = 1'b0;
            len_d[0]  = 1'b0;
        end
        case (cur_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.addr  = base_d;
                    nxt_d.rem   = len_d;
                    nxt_d.we    = req_wr;
                    nxt_d.swap  = !req_raw;
                    nxt_d.first = 1'b1;
                    nxt_d.bidx  = '0;
                    nxt_d.st    = (len_d == '0) ? ST_FIN : ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (mem_gnt) begin
                    nxt_d.addr = cur_q.addr + AW'(2);
                    if (cur_q.rem <= LW'(2)) begin
                        nxt_d.rem = '0;
                        nxt_d.st  = ST_FIN;
                    end else begin
                        nxt_d.rem = cur_q.rem - LW'(2);
                    end
                    if (cur_q.bidx == BIDX_W'(BEATS - 1)) begin
                        nxt_d.bidx  = '0;
                        nxt_d.first = split_d;
                    end else begin
                        nxt_d.bidx  = cur_q.bidx + BIDX_W'(1);
                        nxt_d.first = 1'b0;
                    end
                end
            end
            ST_FIN:  nxt_d.st = ST_IDLE;
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.st    <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready = (cur_q.st == ST_IDLE);
    assign mem_req   = (cur_q.st == ST_MOVE);
    assign mem_we    = cur_q.we;
    assign mem_addr  = cur_q.addr;
    assign mem_be    = (cur_q.rem == LW'(1)) ? 2'b01 : 2'b11;
    assign mem_first = cur_q.first;
    assign swap_on   = cur_q.swap;
    assign done      = (cur_q.st == ST_FIN);

    // R10: a stalled beat keeps its address, enables and burst marker
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_first)));

    // R6: a granted beat that is not the last is followed by the next halfword address
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && cur_q.rem > LW'(2)) |=> (mem_req && mem_addr == $past(mem_addr) + AW'(2)));

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: no new request is taken while beats are outstanding
    assert_busy_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || done) |-> !req_ready);

    // R4: swap-mode beats are full halfwords on even addresses
    assert_swap_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && swap_on) |-> (mem_addr[0] == 1'b0 && mem_be == 2'b11));

    // R7: an empty aligned request completes next cycle without beats
    assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_raw ? (req_len == '0) : (req_len[LW-1:1] == '0)))
        |=> (done && !mem_req));
endmodule

// File: rtl/hswap_dma_path.sv
module hswap_dma_path
    import hswap_pkg::*;
#(
    parameter int AW          = 32,
    parameter int LW          = 16,
    parameter int BURST_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hi_we,
    input  logic [AW-1:0] hi_wdata,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          req_wr,
    input  logic          req_raw,
    input  logic [15:0]   per_wdata,
    output logic          per_wtake,
    output logic [15:0]   per_rdata,
    output logic          per_rvalid,
    output logic          mem_req,
    input  logic          mem_gnt,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_be,
    output logic          mem_first,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic          done
);
    typedef struct packed {
        logic [AW-1:0] hi;
        logic          rvalid;
        logic [15:0]   rdata;
    } top_t;

    top_t top_q, top_d;
    logic        swap_on;
    logic [15:0] rd_swapped;
    logic        beat_fire;

    hswap_seq #(
        .AW          (AW),
        .LW          (LW),
        .BURST_BYTES (BURST_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_wr    (req_wr),
        .req_raw   (req_raw),
        .hi_val    (top_q.hi),
        .mem_gnt   (mem_gnt),
        .req_ready (req_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_first (mem_first),
        .swap_on   (swap_on),
        .done      (done)
    );

    hswap_lane #(.LANES(2)) u_wr_lane (
        .din     (per_wdata),
        .swap_en (swap_on),
        .dout    (mem_wdata)
    );

    hswap_lane #(.LANES(2)) u_rd_lane (
        .din     (mem_rdata),
        .swap_en (swap_on),
        .dout    (rd_swapped)
    );

    assign beat_fire = mem_req && mem_gnt;
    assign per_wtake = beat_fire && mem_we;

    always_comb begin
        top_d        = top_q;
        top_d.rvalid = beat_fire && !mem_we;
        if (beat_fire && !mem_we) begin
            top_d.rdata = rd_swapped;
        end
        if (hi_we) begin
            top_d.hi = hi_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign per_rdata  = top_q.rdata;
    assign per_rvalid = top_q.rvalid;

    // R11: returned data only follows a granted read beat
    assert_rd_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        per_rvalid |-> $past(mem_req && mem_gnt && !mem_we));

    // R10: the peripheral write word is consumed only by a granted write beat
    assert_wtake_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |-> !per_wtake);
endmodule

// File: tb/tb_hswap_dma_path.sv
`timescale 1ns/1ps
module tb_hswap_dma_path;
    localparam int AW = 32;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hi_we = 1'b0;
    logic [AW-1:0] hi_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_wr = 1'b0;
    logic          req_raw = 1'b0;
    logic [15:0]   per_wdata = '0;
    logic          per_wtake;
    logic [15:0]   per_rdata;
    logic          per_rvalid;
    logic          mem_req;
    logic          mem_gnt = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_be;
    logic          mem_first;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata = '0;
    logic          done;

    int nchk = 0;
    int nfail = 0;
    logic [AW-1:0] hi_m = '0;

    always #10 clk = ~clk;

    hswap_dma_path #(.AW(AW), .LW(LW), .BURST_BYTES(64)) dut (
        .clk(clk), .rst_n(rst_n), .hi_we(hi_we), .hi_wdata(hi_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_wr(req_wr), .req_raw(req_raw),
        .per_wdata(per_wdata), .per_wtake(per_wtake), .per_rdata(per_rdata),
        .per_rvalid(per_rvalid), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_first(mem_first), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] sw16(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    task automatic write_hi(input logic [AW-1:0] v);
        @(negedge clk);
        hi_we = 1'b1;
        hi_wdata = v;
        @(negedge clk);
        hi_we = 1'b0;
        hi_m = v;
    endtask

    // One transfer: drives the request, models memory and peripheral, checks every beat.
    task automatic run_xfer(input logic [AW-1:0] a, input int len, input bit wr, input bit raw,
                            input bit stall, input bit hold_req, input bit hi_mid, input string name);
        logic [AW-1:0] base, hold_addr;
        logic [15:0] rd_exp, pw, mr;
        int elen, nbt, nb, last, done_cyc, ndone, cyc;
        int addr_err, be_err, first_err, data_err, rd_err, busy_err, hold_err;
        bit rd_pend, hold_pend, g;
        string dreq;
        base = a | hi_m;
        if (!raw) base[0] = 1'b0;
        elen = raw ? len : (len & ~1);
        nbt = (elen + 1) / 2;
        dreq = raw ? "R3" : "R5";
        nb = 0; last = 0; done_cyc = -1; ndone = 0;
        addr_err = 0; be_err = 0; first_err = 0; data_err = 0; rd_err = 0;
        busy_err = 0; hold_err = 0; rd_pend = 0; hold_pend = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = LW'(len); req_wr = wr; req_raw = raw;
        mem_gnt = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R8", {name, " ready before request"}, req_ready, 1);
        cyc = 0;
        while (!(done_cyc >= 0 && cyc >= done_cyc + 2) && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (hold_req && done_cyc < 0) begin
                req_valid = 1'b1;
                req_addr = 32'h0000_4444; req_len = 16'd40; req_raw = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            if (hi_mid && cyc == 1) begin hi_we = 1'b1; hi_wdata = 32'h0F00_0000; end
            else hi_we = 1'b0;
            g = !(stall && (cyc % 3 == 0));
            mem_gnt = g;
            pw = {8'(8'h30 + nb), 8'(8'hA0 + nb)};
            mr = {8'(8'h5C + nb), 8'(8'h17 + nb)};
            per_wdata = pw;
            mem_rdata = mr;
            #1;
            // R11 returned data
            if (rd_pend) begin
                if (!(per_rvalid && per_rdata == rd_exp)) rd_err++;
            end else if (per_rvalid) rd_err++;
            rd_pend = 1'b0;
            if (hold_pend && !(mem_req && mem_addr == hold_addr)) hold_err++;
            hold_pend = 1'b0;
            if (done_cyc < 0 && req_ready) busy_err++;
            if (done) begin ndone++; if (done_cyc < 0) done_cyc = cyc; end
            if (mem_req && !g) begin
                hold_pend = 1'b1; hold_addr = mem_addr;
                if (per_wtake) hold_err++;
            end
            if (mem_req && g) begin
                if (mem_addr != base + AW'(2 * nb)) addr_err++;
                if (mem_be != ((raw && (elen % 2 == 1) && nb == nbt - 1) ? 2'b01 : 2'b11)) be_err++;
                if (mem_first != ((wr && !raw) ? (nb % 32 == 0) : (nb == 0))) first_err++;
                if (mem_we != wr) data_err++;
                if (wr) begin
                    if (!per_wtake || mem_wdata != (raw ? pw : sw16(pw))) data_err++;
                end else begin
                    rd_pend = 1'b1; rd_exp = raw ? mr : sw16(mr);
                end
                nb++;
                last = cyc;
            end
        end
        if (hi_mid) hi_m = 32'h0F00_0000;
        chk(nb == nbt, raw ? "R3" : "R4", {name, " beat count"}, nb, nbt);
        chk(addr_err == 0, "R2", {name, " beat addresses"}, addr_err, 0);
        chk(be_err == 0, raw ? "R3" : "R4", {name, " byte enables"}, be_err, 0);
        chk(first_err == 0, "R6", {name, " burst markers"}, first_err, 0);
        if (wr) chk(data_err == 0, dreq, {name, " write data lanes"}, data_err, 0);
        else chk(rd_err == 0, "R11", {name, " read data return"}, rd_err, 0);
        chk(ndone == 1 && done_cyc == last + 1, "R9", {name, " done cycle"}, done_cyc, last + 1);
        chk(busy_err == 0, "R8", {name, " busy ready"}, busy_err, 0);
        if (stall) chk(hold_err == 0, "R10", {name, " stall hold"}, hold_err, 0);
        @(negedge clk); #1;
        chk(req_ready && !mem_req && !done, "R8", {name, " idle after"}, {mem_req, done}, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        chk(!mem_req && !done && !per_wtake && !per_rvalid, "R1", "reset outputs quiet",
            {mem_req, done, per_wtake, per_rvalid}, 0);
    endtask

    task automatic t_reset_hi();
        // R1: high register is zero after reset, seen through the first beat address
        run_xfer(32'h0000_0100, 2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1 hi-zero");
    endtask

    task automatic t_zero();
        // R7: aligned length zero
        int mreq_seen;
        run_xfer(32'h0000_0201, 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 swap len1");
        run_xfer(32'h0000_0300, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 raw len0");
        mreq_seen = 0;
        @(negedge clk); req_valid = 1'b1; req_len = 16'd1; req_raw = 1'b0; req_wr = 1'b0;
        @(negedge clk); req_valid = 1'b0; #1;
        if (mem_req) mreq_seen++;
        chk(done == 1'b1 && mreq_seen == 0, "R7", "zero len done next cycle", {done, mem_req}, 2'b10);
    endtask

    initial begin
        t_reset();
        t_reset_hi();
        write_hi(32'h8000_0000);
        run_xfer(32'h0000_1003, 7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 raw write odd");
        run_xfer(32'h0000_2001, 5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 raw read stall");
        run_xfer(32'h0000_3005, 9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 swap write align");
        run_xfer(32'h0000_4000, 6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 swap read stall");
        write_hi(32'h0000_0001);
        run_xfer(32'h0001_0000, 150, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R6 swap burst split");
        run_xfer(32'h0002_0000, 150, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 raw single burst");
        run_xfer(32'h0003_0010, 12, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 busy request");
        t_zero();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule